// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block is a small shared word memory that two requesters reach through one arbitrated access path. Besides plain loads and stores, it performs three indivisible operations: swap (exchange), test-and-set and fetch-and-increment. Each of these reads the addressed word and writes its new value with no other access in between. Every operation gives back the value the word held before the operation.

Software builds locks on top of these operations. A word holding 0 is a free lock and a word holding 1 is a held lock. A requester that swaps in a 1, or applies test-and-set, owns the lock when the old value it gets back is 0. Requests from both ports in the same cycle are ordered by a fixed priority, so exactly one contender ever sees the lock as free.

An accepted request takes two cycles: a read cycle, then a write-back cycle. The unit accepts nothing while a write-back is in progress.

Top module: `atomic_rmw_unit`

## Requirements
- R1: A load (opcode 0) returns the addressed word and leaves it unchanged. Unused opcodes 5, 6 and 7 behave as loads.
- R2: A store (opcode 1) writes the request data into the addressed word. A later load returns that data.
- R3: A swap (opcode 2) returns the old word and writes the request data in its place.
- R4: Fetch-and-increment (opcode 4) returns the old word and writes old+1. The maximum value wraps to 0.
- R5: Test-and-set (opcode 3) returns the old word. It writes 1 only when the old word is 0; otherwise the word is left unchanged.
- R6: At most one grant is given per cycle. When the unit is free and both ports request, port 0 is granted.
- R7: The response valid for a granted port is high for exactly the one cycle after the grant cycle, and the old data is on the read-data output in that same cycle.
- R8: During reset and in the first cycle after it, no response is valid. After reset, every word reads as 0.
- R9: No grant is given in a write-back cycle. When both ports swap 1 into the same free word in the same cycle, port 0 sees 0 and port 1 sees 1.
- R10: A port that is not granted keeps its request raised and is granted on the next cycle in which the unit is free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_req | input | 1 | Port 0 request |
| p0_op | input | 3 | Port 0 opcode |
| p0_addr | input | ADDR_W | Port 0 word address |
| p0_wdata | input | DATA_W | Port 0 write / swap data |
| p0_gnt | output | 1 | Port 0 request accepted this cycle |
| p0_rvalid | output | 1 | Port 0 response valid |
| p0_rdata | output | DATA_W | Old value of the word |
| p1_req | input | 1 | Port 1 request |
| p1_op | input | 3 | Port 1 opcode |
| p1_addr | input | ADDR_W | Port 1 word address |
| p1_wdata | input | DATA_W | Port 1 write / swap data |
| p1_gnt | output | 1 | Port 1 request accepted this cycle |
| p1_rvalid | output | 1 | Port 1 response valid |
| p1_rdata | output | DATA_W | Old value of the word |

## Verification
A grant is combinational and is due in the same cycle as the request, so the bench reads it just after driving the inputs and before the clock edge. The response and old data come one register stage later. The bench therefore checks them at the falling edge after the accepting rising edge, and at that same point it confirms that no grant is offered, because that cycle is the write-back. The bench keeps its own copy of the memory and its own model of when the unit is free. It updates the copy in grant order, and it predicts both the grant winner and the returned value for directed lock races, the wrap case and seeded random traffic on a few contended addresses.

// File: rtl/atomu_pkg.sv
package atomu_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FINC  = 3'd4
  } op_e;
endpackage

// File: rtl/atomu_arbiter.sv
module atomu_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic free,
  input  logic req0,
  input  logic req1,
  output logic gnt0,
  output logic gnt1
);
  always_comb begin
    gnt0 = free && req0;
    gnt1 = free && req1 && !req0;
  end

  p_one_grant_r6: assert property (@(posedge clk) disable iff (rst)
    !(gnt0 && gnt1));
  p_port0_first_r6: assert property (@(posedge clk) disable iff (rst)
    (free && req0 && req1) |-> (gnt0 && !gnt1));
endmodule

// File: rtl/atomu_alu.sv
module atomu_alu #(
  parameter int DATA_W = 8
) (
  input  atomu_pkg::op_e     op,
  input  logic [DATA_W-1:0]  old_val,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  new_val,
  output logic               wr_en
);
  import atomu_pkg::*;
  always_comb begin
    new_val = old_val;
    wr_en   = 1'b0;
    case (op)
      OP_STORE, OP_SWAP: begin
        new_val = wdata;
        wr_en   = 1'b1;
      end
      OP_TAS: begin
        new_val = DATA_W'(1);
        wr_en   = (old_val == '0);
      end
      OP_FINC: begin
        new_val = old_val + DATA_W'(1);
        wr_en   = 1'b1;
      end
      default: begin
        new_val = old_val;
        wr_en   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/atomu_mem.sv
module atomu_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] ram [DEPTH];
  logic [DEPTH-1:0]  written_q;
  logic [DATA_W-1:0] rd_q;
  logic              rd_written_q;

  // data array: no reset, so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_addr] <= wr_data;
    if (rd_en) rd_q <= ram[rd_addr];
  end

  // per-word flags make every word read as zero after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      written_q    <= '0;
      rd_written_q <= 1'b0;
    end else begin
      if (wr_en) written_q[wr_addr] <= 1'b1;
      if (rd_en) rd_written_q <= written_q[rd_addr];
    end
  end

  assign rd_data = rd_written_q ? rd_q : '0;
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              p0_req,
  input  logic [2:0]        p0_op,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [DATA_W-1:0] p0_wdata,
  output logic              p0_gnt,
  output logic              p0_rvalid,
  output logic [DATA_W-1:0] p0_rdata,
  input  logic              p1_req,
  input  logic [2:0]        p1_op,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [DATA_W-1:0] p1_wdata,
  output logic              p1_gnt,
  output logic              p1_rvalid,
  output logic [DATA_W-1:0] p1_rdata
);
  import atomu_pkg::*;

  logic              busy_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rsp0_q, rsp1_q;
  logic              accept;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] old_val, new_val;
  logic              alu_we, mem_we;

  atomu_arbiter u_arb (
    .clk(clk), .rst(rst), .free(!busy_q),
    .req0(p0_req), .req1(p1_req), .gnt0(p0_gnt), .gnt1(p1_gnt)
  );

  assign accept   = p0_gnt || p1_gnt;
  assign sel_addr = p0_gnt ? p0_addr : p1_addr;

  // read cycle: latch the winning request
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      rsp0_q  <= 1'b0;
      rsp1_q  <= 1'b0;
      op_q    <= OP_LOAD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      busy_q <= accept;
      rsp0_q <= p0_gnt;
      rsp1_q <= p1_gnt;
      if (accept) begin
        op_q    <= p0_gnt ? op_e'(p0_op) : op_e'(p1_op);
        addr_q  <= sel_addr;
        wdata_q <= p0_gnt ? p0_wdata : p1_wdata;
      end
    end
  end

  atomu_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst(rst),
    .rd_en(accept), .rd_addr(sel_addr),
    .wr_en(mem_we), .wr_addr(addr_q), .wr_data(new_val),
    .rd_data(old_val)
  );

  atomu_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op_q), .old_val(old_val), .wdata(wdata_q),
    .new_val(new_val), .wr_en(alu_we)
  );

  // write-back cycle
  assign mem_we    = busy_q && alu_we;
  assign p0_rvalid = rsp0_q;
  assign p1_rvalid = rsp1_q;
  assign p0_rdata  = old_val;
  assign p1_rdata  = old_val;

  p_rsp0_next_r7: assert property (@(posedge clk) disable iff (rst)
    p0_gnt |=> (p0_rvalid && !p1_rvalid));
  p_rsp1_next_r7: assert property (@(posedge clk) disable iff (rst)
    p1_gnt |=> (p1_rvalid && !p0_rvalid));
  p_no_grant_in_wb_r9: assert property (@(posedge clk) disable iff (rst)
    (p0_rvalid || p1_rvalid) |-> !(p0_gnt || p1_gnt));
  p_finc_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && op_q == OP_FINC) |-> (mem_we && new_val == old_val + DATA_W'(1)));
  p_tas_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && op_q == OP_TAS && old_val != '0) |-> !mem_we);
  p_quiet_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!p0_rvalid && !p1_rvalid));
endmodule

// File: tb/sim_atomic_rmw_unit.sv
module sim_atomic_rmw_unit;
  localparam int DW = 8;
  localparam int DEP = 16;
  localparam int AW = $clog2(DEP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic p0_req = 0, p1_req = 0;
  logic [2:0] p0_op = 0, p1_op = 0;
  logic [AW-1:0] p0_addr = 0, p1_addr = 0;
  logic [DW-1:0] p0_wdata = 0, p1_wdata = 0;
  logic p0_gnt, p1_gnt, p0_rvalid, p1_rvalid;
  logic [DW-1:0] p0_rdata, p1_rdata;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit free_b = 1'b1;
  logic [DW-1:0] mdl [DEP];

  always #2.5 clk = ~clk;

  atomic_rmw_unit #(.DATA_W(DW), .DEPTH(DEP)) u0 (
    .clk(clk), .rst(rst),
    .p0_req(p0_req), .p0_op(p0_op), .p0_addr(p0_addr), .p0_wdata(p0_wdata),
    .p0_gnt(p0_gnt), .p0_rvalid(p0_rvalid), .p0_rdata(p0_rdata),
    .p1_req(p1_req), .p1_op(p1_op), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
    .p1_gnt(p1_gnt), .p1_rvalid(p1_rvalid), .p1_rdata(p1_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd1: return "R2 store";
      3'd2: return "R3 swap";
      3'd3: return "R5 test-and-set";
      3'd4: return "R4 fetch-inc";
      default: return "R1 load";
    endcase
  endfunction

  // model: returns old value, updates bench copy of memory
  function automatic logic [DW-1:0] apply(input logic [2:0] op, input logic [AW-1:0] a,
                                          input logic [DW-1:0] wd);
    logic [DW-1:0] old;
    old = mdl[a];
    case (op)
      3'd1, 3'd2: mdl[a] = wd;
      3'd3: if (old == 0) mdl[a] = 1;
      3'd4: mdl[a] = old + 1;
      default: ;
    endcase
    return old;
  endfunction

  // drives up to two requests at once and follows them cycle by cycle
  task automatic run_pair(input bit v0, input logic [2:0] o0, input logic [AW-1:0] a0,
                          input logic [DW-1:0] d0, input bit v1, input logic [2:0] o1,
                          input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                          output logic [DW-1:0] r0, output logic [DW-1:0] r1);
    bit pend0, pend1, g0, g1, eg0, eg1;
    logic [DW-1:0] exp;
    pend0 = v0; pend1 = v1; r0 = 'x; r1 = 'x;
    p0_req = v0; p0_op = o0; p0_addr = a0; p0_wdata = d0;
    p1_req = v1; p1_op = o1; p1_addr = a1; p1_wdata = d1;
    while (pend0 || pend1) begin
      #1;
      g0 = p0_gnt; g1 = p1_gnt;
      eg0 = free_b && pend0;
      eg1 = free_b && pend1 && !pend0;
      chk("R6/R9/R10 grant port0", 32'(g0), 32'(eg0));
      chk("R6/R9/R10 grant port1", 32'(g1), 32'(eg1));
      @(posedge clk);
      @(negedge clk);
      chk("R7 rvalid port0", 32'(p0_rvalid), 32'(g0));
      chk("R7 rvalid port1", 32'(p1_rvalid), 32'(g1));
      if (g0) begin
        exp = apply(o0, a0, d0);
        r0 = p0_rdata;
        if (o0 != 3'd1) chk(op_tag(o0), 32'(p0_rdata), 32'(exp));
        pend0 = 0; p0_req = 0;
      end
      if (g1) begin
        exp = apply(o1, a1, d1);
        r1 = p1_rdata;
        if (o1 != 3'd1) chk(op_tag(o1), 32'(p1_rdata), 32'(exp));
        pend1 = 0; p1_req = 0;
      end
      free_b = !(g0 || g1);
    end
  endtask

  task automatic one(input bit port, input logic [2:0] op, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, output logic [DW-1:0] r);
    logic [DW-1:0] x;
    if (port) run_pair(0, 0, 0, 0, 1, op, a, d, x, r);
    else      run_pair(1, op, a, d, 0, 0, 0, 0, r, x);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r0, r1;
    for (int i = 0; i < DEP; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    chk("R8 rvalid0 in reset", 32'(p0_rvalid), 0);
    chk("R8 rvalid1 in reset", 32'(p1_rvalid), 0);
    rst = 0;
    @(negedge clk);
    chk("R8 rvalid0 after reset", 32'(p0_rvalid), 0);
    chk("R8 rvalid1 after reset", 32'(p1_rvalid), 0);
    // R8: words read zero after reset
    one(0, 3'd0, 4'd0, 0, r0);
    chk("R8 word0 zero", 32'(r0), 0);
    one(1, 3'd0, 4'd15, 0, r1);
    chk("R8 word15 zero", 32'(r1), 0);
    // R9: lock race, both swap 1 into free word 5
    run_pair(1, 3'd2, 4'd5, 1, 1, 3'd2, 4'd5, 1, r0, r1);
    chk("R9 race port0 sees free", 32'(r0), 0);
    chk("R9 race port1 sees held", 32'(r1), 1);
    // R5: test-and-set race on word 6
    run_pair(1, 3'd3, 4'd6, 0, 1, 3'd3, 4'd6, 0, r0, r1);
    chk("R5 tas port0 old", 32'(r0), 0);
    chk("R5 tas port1 old", 32'(r1), 1);
    one(0, 3'd1, 4'd7, 8'h2a, r0);
    one(1, 3'd3, 4'd7, 0, r1);
    one(0, 3'd0, 4'd7, 0, r0);
    chk("R5 tas leaves nonzero word", 32'(r0), 32'h2a);
    // R2/R1: store then loads, including unused opcodes
    one(1, 3'd1, 4'd3, 8'h5c, r1);
    one(0, 3'd7, 4'd3, 0, r0);
    chk("R1 opcode7 as load", 32'(r0), 32'h5c);
    one(1, 3'd5, 4'd3, 0, r1);
    chk("R2 store visible / R1 unchanged", 32'(r1), 32'h5c);
    // R4: wrap
    one(0, 3'd1, 4'd9, 8'hff, r0);
    one(1, 3'd4, 4'd9, 0, r1);
    chk("R4 finc old max", 32'(r1), 32'hff);
    one(0, 3'd0, 4'd9, 0, r0);
    chk("R4 finc wraps", 32'(r0), 0);
    // R3: swap returns old
    one(1, 3'd2, 4'd9, 8'h77, r1);
    one(0, 3'd2, 4'd9, 8'h11, r0);
    chk("R3 swap old", 32'(r0), 32'h77);
    // random traffic on a few contended words
    void'($urandom(32'd1234));
    for (int k = 0; k < 400; k++) begin
      bit v0, v1;
      v0 = 1'($urandom); v1 = 1'($urandom);
      run_pair(v0, 3'($urandom % 8), AW'($urandom % 4), DW'($urandom),
               v1, 3'($urandom % 8), AW'($urandom % 4), DW'($urandom), r0, r1);
      if (k % 8 == 0) repeat (1) @(negedge clk);
      if (k % 8 == 0) free_b = 1'b1;
    end
    for (int i = 0; i < 4; i++) one(i[0], 3'd0, AW'(i), 0, r0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule